// File: doc/BRIEF.md
# NRZI Framed Serial Transmitter

This block turns a frame of 16-bit words into a single-bit line level. A frame is a three-bit sync pattern of ones, then a 16-bit header word, then the number of 16-bit payload words that the header announces. Each bit travels as a level transition for a one and a held level for a zero. After six zeros in a row, the transmitter inserts one extra one bit, so the line never stays flat for long. The run counter for this rule covers idle time and every part of the frame.

Words come in through a ready/valid handshake. The first word accepted while the block is idle is the header, and its low eight bits give the payload word count. The following accepted words are payload words. A bit-rate enable input, high for one system clock in every bit period, sets the pace. Without a frame the line carries zeros plus the stuffed ones, so it toggles once every seven bit periods. If a payload word is late, the block sends filler zeros until the word arrives. Stuffing still applies to those zeros.

Top module: `nrzi_frame_tx`

## Requirements
- R1: After reset the line level is 0 and `in_ready` is 1.
- R2: In each bit slot a one bit inverts the line level and a zero bit keeps it.
- R3: When the six preceding bit slots all carried zeros, the slot carries an extra one that consumes no frame bit. Any one bit restarts the zero count, whether it is a data bit or a stuffed bit.
- R4: With no frame pending, every slot carries a zero apart from the stuffed ones, so the line toggles every seventh slot.
- R5: Once a header is accepted, the next three non-stuffed slots carry ones.
- R6: The 16 header bits follow the sync, most significant bit first.
- R7: The payload word count is header bits [7:0]. Each word goes out most significant bit first, and with a count of 0 the frame ends after the header.
- R8: `in_ready` is 1 only while no accepted bit is waiting to be sent, which is when idle or between payload words. A word is taken on a clock edge with `in_valid` and `in_ready` both high.
- R9: The line changes only on clock edges where `bit_en` is high.
- R10: If the next payload word is missing when a slot comes, the slot carries a filler zero. The frame resumes with that word once it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-cycle strobe per bit period |
| in_valid | input | 1 | Word offered |
| in_data | input | 16 | Header or payload word |
| in_ready | output | 1 | Block can take a word |
| line_out | output | 1 | Coded line level |

## Verification
Most internal faults in this block appear on the line within one bit slot. A zero-run count that is off by one moves a stuffed transition at least one slot from where a decoder of the line expects it, and a wrong shift position flips a decoded data bit in that slot. A state register in the wrong state shows on `in_ready` on the very next clock, because ready has to track exactly whether accepted bits are still waiting. Frame-length faults show up when the frame ends early or late: either the idle pattern appears before the last payload bit, or ready rises when the count says the frame is already over.

// File: rtl/nrzi_tx_pkg.sv
package nrzi_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SYNC,
    ST_HDR,
    ST_WAIT,
    ST_PAY
  } tx_state_e;

  // Line level after one bit slot: a one inverts, a zero holds.
  function automatic logic level_after(input logic level, input logic bit_val);
    return level ^ bit_val;
  endfunction

  // A stuffed one is due once the zero run has reached its limit.
  function automatic logic stuff_due(input int unsigned run, input int unsigned limit);
    return run == limit;
  endfunction

  // Zero-run count after a slot that carried bit_val.
  function automatic int unsigned run_after(input int unsigned run, input logic bit_val);
    return bit_val ? 0 : run + 1;
  endfunction

endpackage

// File: rtl/nrzi_tx_framer.sv
module nrzi_tx_framer
  import nrzi_tx_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int LEN_W    = 8,
  parameter int SYNC_LEN = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              in_ready,
  input  logic              take,
  output logic              frame_bit,
  output logic              hdr_accept,
  output logic              word_accept,
  output logic              last_bit
);
  localparam int CNT_MAX = (WORD_W > SYNC_LEN) ? WORD_W : SYNC_LEN;
  localparam int CNT_W   = (CNT_MAX > 1) ? $clog2(CNT_MAX) : 1;

  tx_state_e         state;
  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  bit_cnt;
  logic [LEN_W-1:0]  words_left;
  logic              has_bit;
  logic              consume;

  assign has_bit     = (state == ST_SYNC) || (state == ST_HDR) || (state == ST_PAY);
  assign in_ready    = (state == ST_IDLE) || (state == ST_WAIT);
  assign hdr_accept  = in_valid && (state == ST_IDLE);
  assign word_accept = in_valid && (state == ST_WAIT);
  assign consume     = take && has_bit;
  assign last_bit    = consume && (bit_cnt == '0);

  always_comb begin
    case (state)
      ST_SYNC:        frame_bit = 1'b1;
      ST_HDR, ST_PAY: frame_bit = shreg[WORD_W-1];
      default:        frame_bit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      shreg      <= '0;
      bit_cnt    <= '0;
      words_left <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (hdr_accept) begin
            shreg      <= in_data;
            words_left <= in_data[LEN_W-1:0];
            bit_cnt    <= CNT_W'(SYNC_LEN - 1);
            state      <= ST_SYNC;
          end
        end
        ST_SYNC: begin
          if (consume) begin
            if (bit_cnt == '0) begin
              bit_cnt <= CNT_W'(WORD_W - 1);
              state   <= ST_HDR;
            end else begin
              bit_cnt <= bit_cnt - 1'b1;
            end
          end
        end
        ST_HDR, ST_PAY: begin
          if (consume) begin
            shreg <= {shreg[WORD_W-2:0], 1'b0};
            if (bit_cnt == '0) begin
              state <= (words_left == '0) ? ST_IDLE : ST_WAIT;
            end else begin
              bit_cnt <= bit_cnt - 1'b1;
            end
          end
        end
        ST_WAIT: begin
          if (word_accept) begin
            shreg      <= in_data;
            bit_cnt    <= CNT_W'(WORD_W - 1);
            words_left <= words_left - 1'b1;
            state      <= ST_PAY;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/nrzi_tx_stuffer.sv
module nrzi_tx_stuffer
  import nrzi_tx_pkg::*;
#(
  parameter int STUFF_RUN = 6,
  parameter int RUN_W     = $clog2(STUFF_RUN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             frame_bit,
  output logic             slot_bit,
  output logic             stuff_now,
  output logic             take,
  output logic [RUN_W-1:0] run
);
  assign stuff_now = stuff_due(int'(run), STUFF_RUN);
  assign slot_bit  = stuff_now || frame_bit;
  assign take      = bit_en && !stuff_now;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= '0;
    end else if (bit_en) begin
      run <= RUN_W'(run_after(int'(run), slot_bit));
    end
  end

endmodule

// File: rtl/nrzi_tx_line.sv
module nrzi_tx_line
  import nrzi_tx_pkg::*;
#(
  parameter logic INIT_LEVEL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic slot_bit,
  output logic line_out
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_out <= INIT_LEVEL;
    end else if (bit_en) begin
      line_out <= level_after(line_out, slot_bit);
    end
  end

endmodule

// File: rtl/nrzi_frame_tx.sv
module nrzi_frame_tx #(
  parameter int   WORD_W     = 16,
  parameter int   LEN_W      = 8,
  parameter int   SYNC_LEN   = 3,
  parameter int   STUFF_RUN  = 6,
  parameter logic INIT_LEVEL = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              in_ready,
  output logic              line_out
);
  localparam int RUN_W = $clog2(STUFF_RUN + 1);

  logic             frame_bit;
  logic             slot_bit;
  logic             stuff_now;
  logic             take;
  logic             hdr_accept;
  logic             word_accept;
  logic             last_bit;
  logic [RUN_W-1:0] run;

  nrzi_tx_framer #(
    .WORD_W  (WORD_W),
    .LEN_W   (LEN_W),
    .SYNC_LEN(SYNC_LEN)
  ) u_framer (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .in_ready   (in_ready),
    .take       (take),
    .frame_bit  (frame_bit),
    .hdr_accept (hdr_accept),
    .word_accept(word_accept),
    .last_bit   (last_bit)
  );

  nrzi_tx_stuffer #(
    .STUFF_RUN(STUFF_RUN),
    .RUN_W    (RUN_W)
  ) u_stuffer (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_en   (bit_en),
    .frame_bit(frame_bit),
    .slot_bit (slot_bit),
    .stuff_now(stuff_now),
    .take     (take),
    .run      (run)
  );

  nrzi_tx_line #(
    .INIT_LEVEL(INIT_LEVEL)
  ) u_line (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_en  (bit_en),
    .slot_bit(slot_bit),
    .line_out(line_out)
  );

endmodule

// File: rtl/nrzi_frame_tx_chk.sv
module nrzi_frame_tx_chk #(
  parameter int STUFF_RUN = 6,
  parameter int RUN_W     = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_en,
  input logic             slot_bit,
  input logic             stuff_now,
  input logic             line_out,
  input logic             in_ready,
  input logic             hdr_accept,
  input logic             word_accept,
  input logic             frame_bit,
  input logic [RUN_W-1:0] run
);
  p_one_toggles_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && slot_bit) |=> (line_out != $past(line_out)));

  p_zero_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !slot_bit) |=> (line_out == $past(line_out)));

  p_quiet_between_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(line_out));

  p_run_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(run) <= STUFF_RUN));

  p_stuff_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && stuff_now) |=> (run == '0));

  p_sync_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_accept |=> frame_bit);

  p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_accept || word_accept) |=> !in_ready);

  p_single_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hdr_accept, word_accept}));

endmodule

bind nrzi_frame_tx nrzi_frame_tx_chk #(
  .STUFF_RUN(STUFF_RUN),
  .RUN_W    (RUN_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bit_en     (bit_en),
  .slot_bit   (slot_bit),
  .stuff_now  (stuff_now),
  .line_out   (line_out),
  .in_ready   (in_ready),
  .hdr_accept (hdr_accept),
  .word_accept(word_accept),
  .frame_bit  (frame_bit),
  .run        (run)
);

// File: tb/nrzi_frame_tx_tb.sv
module nrzi_frame_tx_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_en = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic        in_ready;
  logic        line_out;

  int checks = 0;
  int errors = 0;
  int div = 2;
  bit mon_on = 1'b0;
  bit done = 1'b0;

  // expected unstuffed bit queue with requirement codes
  bit  rawq[$];
  byte tagq[$];
  int  words_left = 0;
  bit  expect_hdr = 1'b1;
  int  run_m = 0;

  logic [15:0] wbuf [8];

  always #4 clk = ~clk;

  nrzi_frame_tx u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_en  (bit_en),
    .in_valid(in_valid),
    .in_data (in_data),
    .in_ready(in_ready),
    .line_out(line_out)
  );

  function automatic string tag_name(input byte t);
    case (t)
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      7: return "R7";
      8: return "R8";
      9: return "R9";
      10: return "R10";
      default: return "R1";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // bit-rate strobe: one cycle in every div
  initial begin
    int cnt = 0;
    forever begin
      @(posedge clk);
      #1;
      cnt++;
      bit_en = rst_n && (cnt % div == 0);
    end
  end

  // monitor / scoreboard
  initial begin
    bit  last_line = 1'b0;
    bit  pending = 1'b0;
    bit  exp_bit = 1'b0;
    byte exp_tag = 2;
    bit  first = 1'b1;
    wait (mon_on);
    forever begin
      @(negedge clk);
      if (!first) begin
        if (pending)
          check(line_out == (last_line ^ exp_bit), tag_name(exp_tag),
                int'(line_out), int'(last_line ^ exp_bit));
        else
          check(line_out == last_line, "R9", int'(line_out), int'(last_line));
      end
      first = 1'b0;
      // R8: ready exactly when nothing accepted is waiting
      check(in_ready == (rawq.size() == 0), "R8", int'(in_ready), int'(rawq.size() == 0));
      last_line = line_out;
      pending = 1'b0;
      if (bit_en) begin
        pending = 1'b1;
        if (run_m == 6) begin
          exp_bit = 1'b1; exp_tag = 3;
        end else if (rawq.size() != 0) begin
          exp_bit = rawq.pop_front(); exp_tag = tagq.pop_front();
        end else begin
          exp_bit = 1'b0; exp_tag = (words_left > 0) ? 10 : 4;
        end
        run_m = exp_bit ? 0 : run_m + 1;
      end
      if (in_valid && in_ready) begin
        if (expect_hdr) begin
          for (int i = 0; i < 3; i++) begin rawq.push_back(1'b1); tagq.push_back(5); end
          for (int i = 15; i >= 0; i--) begin rawq.push_back(in_data[i]); tagq.push_back(6); end
          words_left = int'(in_data[7:0]);
          expect_hdr = (words_left == 0);
        end else begin
          for (int i = 15; i >= 0; i--) begin rawq.push_back(in_data[i]); tagq.push_back(7); end
          words_left--;
          if (words_left == 0) expect_hdr = 1'b1;
        end
      end
    end
  end

  // driver: header then n words; gap cycles of no valid before word gap_idx
  task automatic send_frame(input logic [15:0] hdr, input int n, input int gap_idx, input int gap);
    for (int k = 0; k <= n; k++) begin
      if (k > 0 && k - 1 == gap_idx) begin
        in_valid = 1'b0;
        repeat (gap) @(posedge clk);
        #1;
      end
      in_valid = 1'b1;
      in_data = (k == 0) ? hdr : wbuf[k-1];
      do @(negedge clk); while (!in_ready);
      @(posedge clk);
      #1;
    end
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (rawq.size() != 0 || words_left != 0) @(posedge clk);
    repeat (4) @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    check(line_out == 1'b0, "R1", int'(line_out), 0);
    check(in_ready == 1'b1, "R1", int'(in_ready), 1);
    mon_on = 1'b1;

    // R4 idle with stuffing
    repeat (100) @(posedge clk);
    #1;

    // R5 R6 R7 R3: frame of three words, zeros force stuffing inside payload
    wbuf[0] = 16'h8001; wbuf[1] = 16'h0000; wbuf[2] = 16'hFFFF;
    send_frame(16'hA503, 3, -1, 0);
    drain();

    // R7: zero-length frame ends after the header
    send_frame(16'h3C00, 0, -1, 0);
    drain();

    // R10: slower strobe and a late second word
    div = 3;
    wbuf[0] = 16'h1234; wbuf[1] = 16'h00F0;
    send_frame(16'h5A02, 2, 1, 60);
    drain();

    // back-to-back frames
    div = 2;
    wbuf[0] = 16'hC003;
    send_frame(16'h0101, 1, -1, 0);
    send_frame(16'h7E00, 0, -1, 0);
    drain();
    repeat (40) @(posedge clk);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule